// File: doc/BRIEF.md
# Sensor Mode-Change Sequencer

This block changes the operating mode of an image sensor without disturbing a frame in progress. It takes one request bit for each mode (test pattern, full frame, binning), a level from the sensor that marks when its registers may safely be rewritten, and the accept signal of a register-write port. No write leaves the block unless the sensor has raised its ready level and a mode request has arrived during that window. The block then issues the fixed list of register writes for the chosen mode, one entry per accepted write. After the last write it goes back to idle and raises a one-cycle done pulse.

There are five states. `ST_IDLE` waits for the ready level (transition IDLE→HOLD). `ST_HOLD` stays in place by default while ready is high and no mode is requested. If ready drops it takes HOLD→IDLE. If a request bit is set it takes HOLD→CFG_TP, HOLD→CFG_BIN or HOLD→CFG_FULL. Each of `ST_CFG_TP`, `ST_CFG_BIN` and `ST_CFG_FULL` holds on one table entry until that write is accepted, then moves to the next entry. When the last entry is accepted it takes CFG→IDLE. The next-state logic first assigns the current state and then overrides it under any true condition, and the later assignment wins.

Top module: `msq_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle with `wr_req` and `done` low on the cycle after the reset edge, and abandons any sequence in progress.
- R2: No write is requested while `sns_ready` is low. Mode requests made while ready is low have no effect.
- R3: With ready high and no request bit set, the block waits for any number of cycles without writing. A request that arrives later starts the sequence for that mode.
- R4: If `sns_ready` falls while the block waits for a request, the block returns to idle. A request made after that with ready low produces no write.
- R5: `mode_req` bit 0 selects test pattern, bit 1 full frame and bit 2 binning. When several bits are set, test pattern wins over binning and binning wins over full frame.
- R6: The test-pattern sequence is 3 writes. Write i (from 0) has address 0x10+i and data 0xA0+i.
- R7: The binning sequence is 4 writes with address 0x20+i and data 0xB0+i. The full-frame sequence is 2 writes with address 0x30+i and data 0xC0+i.
- R8: `wr_req` stays high and `reg_addr`/`reg_data` stay unchanged until `wr_ack` is high at a clock edge. Each accepted write moves the sequence on by exactly one entry.
- R9: Once a sequence has started, changes on `mode_req` and `sns_ready` have no effect on it.
- R10: `done` is high for exactly one cycle, the cycle after the last write of a sequence is accepted. In that cycle `wr_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_req | input | 3 | Mode request bits: 0 test pattern, 1 full frame, 2 binning |
| sns_ready | input | 1 | Sensor level allowing register rewrites |
| wr_ack | input | 1 | Write port accepts the current write at this edge |
| reg_addr | output | ADDR_W | Register address of the current write |
| reg_data | output | DATA_W | Register data of the current write |
| wr_req | output | 1 | A write is being offered |
| done | output | 1 | One-cycle pulse after the final write of a sequence |

## Verification
The assertions check on every cycle that each write burst begins only after a cycle with ready high. They also check that a stalled write keeps its address and data, that done lasts one cycle, follows an accepted write and never coincides with a write, and that the reset edge silences the outputs. Only the bench scenarios can show which table entries appear and in what order. The same holds for the priority among simultaneous requests, for requests ignored while ready is low or during a sequence, for the return to idle when ready drops while waiting, and for abandoning a sequence on reset.

// File: rtl/msq_pkg.sv
package msq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_CFG_TP,
        ST_CFG_BIN,
        ST_CFG_FULL
    } msq_state_t;

    typedef enum logic [1:0] {
        MD_NONE,
        MD_TP,
        MD_BIN,
        MD_FULL
    } msq_mode_t;

    // Bit positions inside the request vector
    localparam int REQ_TP   = 0;
    localparam int REQ_FULL = 1;
    localparam int REQ_BIN  = 2;
    localparam int NUM_REQ  = 3;
    localparam int NUM_SEQ  = 3;

    function automatic logic [7:0] seq_addr_base(input int lane);
        case (lane)
            0:       return 8'h10;
            1:       return 8'h20;
            default: return 8'h30;
        endcase
    endfunction

    function automatic logic [7:0] seq_data_base(input int lane);
        case (lane)
            0:       return 8'hA0;
            1:       return 8'hB0;
            default: return 8'hC0;
        endcase
    endfunction

endpackage

// File: rtl/msq_prio_pick.sv
module msq_prio_pick
    import msq_pkg::*;
#(
    parameter int REQ_W = NUM_REQ
) (
    input  logic [REQ_W-1:0] req,
    output msq_mode_t        pick
);

    always_comb begin
        pick = MD_NONE;
        if (req[REQ_TP])
            pick = MD_TP;
        else if (req[REQ_BIN])
            pick = MD_BIN;
        else if (req[REQ_FULL])
            pick = MD_FULL;
    end

endmodule

// File: rtl/msq_entry_gen.sv
module msq_entry_gen
    import msq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 2,
    parameter int TP_LEN   = 3,
    parameter int BIN_LEN  = 4,
    parameter int FULL_LEN = 2
) (
    input  msq_mode_t         mode,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              last
);

    logic [ADDR_W-1:0] lane_addr [NUM_SEQ];
    logic [DATA_W-1:0] lane_data [NUM_SEQ];
    logic              lane_last [NUM_SEQ];

    // One lane per sequence; lane 0 test pattern, 1 binning, 2 full frame
    for (genvar g = 0; g < NUM_SEQ; g++) begin : g_lane
        localparam int LEN = (g == 0) ? TP_LEN : (g == 1) ? BIN_LEN : FULL_LEN;
        always_comb begin
            lane_addr[g] = ADDR_W'(seq_addr_base(g)) + ADDR_W'(idx);
            lane_data[g] = DATA_W'(seq_data_base(g)) + DATA_W'(idx);
            lane_last[g] = (idx == IDX_W'(LEN - 1));
        end
    end

    always_comb begin
        addr = '0;
        data = '0;
        last = 1'b0;
        unique case (mode)
            MD_TP: begin
                addr = lane_addr[0];
                data = lane_data[0];
                last = lane_last[0];
            end
            MD_BIN: begin
                addr = lane_addr[1];
                data = lane_data[1];
                last = lane_last[1];
            end
            MD_FULL: begin
                addr = lane_addr[2];
                data = lane_data[2];
                last = lane_last[2];
            end
            default: begin
                addr = '0;
                data = '0;
                last = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/msq_step_ctr.sv
module msq_step_ctr #(
    parameter int IDX_W   = 2,
    parameter int MAX_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (adv && wrap)
            idx <= '0;
        else if (adv)
            idx <= idx + 1'b1;
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(idx) < MAX_LEN); // R8

endmodule

// File: rtl/msq_seq.sv
module msq_seq
    import msq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int TP_LEN   = 3,
    parameter int BIN_LEN  = 4,
    parameter int FULL_LEN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_req,
    input  logic              sns_ready,
    input  logic              wr_ack,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_data,
    output logic              wr_req,
    output logic              done
);

    localparam int MAX_A   = (TP_LEN > BIN_LEN) ? TP_LEN : BIN_LEN;
    localparam int MAX_LEN = (MAX_A > FULL_LEN) ? MAX_A : FULL_LEN;
    localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    msq_state_t       state;
    msq_state_t       nxt;
    msq_mode_t        pick;
    msq_mode_t        act_mode;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             in_cfg;
    logic             accept;

    msq_prio_pick #(.REQ_W(NUM_REQ)) u_pick (
        .req  (mode_req),
        .pick (pick)
    );

    msq_entry_gen #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .TP_LEN   (TP_LEN),
        .BIN_LEN  (BIN_LEN),
        .FULL_LEN (FULL_LEN)
    ) u_gen (
        .mode (act_mode),
        .idx  (idx),
        .addr (reg_addr),
        .data (reg_data),
        .last (last)
    );

    msq_step_ctr #(.IDX_W(IDX_W), .MAX_LEN(MAX_LEN)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (!in_cfg),
        .adv  (accept),
        .wrap (last),
        .idx  (idx)
    );

    // Next state: hold by default, later assignments override
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sns_ready)
                    nxt = ST_HOLD;
            end
            ST_HOLD: begin
                nxt = ST_HOLD;
                if (!sns_ready)
                    nxt = ST_IDLE;
                else if (pick == MD_TP)
                    nxt = ST_CFG_TP;
                else if (pick == MD_BIN)
                    nxt = ST_CFG_BIN;
                else if (pick == MD_FULL)
                    nxt = ST_CFG_FULL;
            end
            ST_CFG_TP, ST_CFG_BIN, ST_CFG_FULL: begin
                if (wr_ack && last)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and done pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= accept && last;
        end
    end

    // Moore outputs decoded from the state
    always_comb begin
        act_mode = MD_NONE;
        in_cfg   = 1'b0;
        unique case (state)
            ST_CFG_TP:   begin act_mode = MD_TP;   in_cfg = 1'b1; end
            ST_CFG_BIN:  begin act_mode = MD_BIN;  in_cfg = 1'b1; end
            ST_CFG_FULL: begin act_mode = MD_FULL; in_cfg = 1'b1; end
            default:     begin act_mode = MD_NONE; in_cfg = 1'b0; end
        endcase
        wr_req = in_cfg;
        accept = in_cfg && wr_ack;
    end

    AST_WRITE_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_req) |-> $past(sns_ready)); // R2

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(reg_addr) && $stable(reg_data))); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_req && wr_ack)); // R10

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_req); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wr_req && !done)); // R1

endmodule

// File: tb/sim_msq_seq.sv
module sim_msq_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        bit         last;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_req = 3'b000;
    logic       sns_ready = 1'b0;
    logic       wr_ack = 1'b0;
    logic [7:0] reg_addr;
    logic [7:0] reg_data;
    logic       wr_req;
    logic       done;

    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];
    int   ack_delay = 0;
    int   wait_cnt = 0;
    bit   exp_done = 0;
    bit   nack;

    always #(CLK_PERIOD/2) clk = ~clk;

    msq_seq u0 (
        .clk       (clk),
        .rst       (rst),
        .mode_req  (mode_req),
        .sns_ready (sns_ready),
        .wr_ack    (wr_ack),
        .reg_addr  (reg_addr),
        .reg_data  (reg_data),
        .wr_req    (wr_req),
        .done      (done)
    );

    // Monitor and write responder: sample stable outputs, decide the ack
    always @(negedge clk) begin
        if (rst) begin
            wr_ack   = 1'b0;
            wait_cnt = 0;
            exp_done = 0;
        end else begin
            if (done || exp_done) begin
                checks++;
                if (done !== exp_done) begin
                    errors++;
                    $display("FAIL R10 done actual %0b expected %0b", done, exp_done);
                end
            end
            exp_done = 0;
            nack = 0;
            if (wr_req) begin
                if (wait_cnt >= ack_delay) nack = 1;
                else wait_cnt++;
            end
            if (nack) begin
                wait_cnt = 0;
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected write actual %02h/%02h expected none",
                             reg_addr, reg_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (reg_addr !== e.a || reg_data !== e.d) begin
                        errors++;
                        $display("FAIL R6/R7 write actual %02h/%02h expected %02h/%02h",
                                 reg_addr, reg_data, e.a, e.d);
                    end
                    if (e.last) exp_done = 1;
                end
            end
            wr_ack = nack;
        end
    end

    // Mode picked from the request bits (R5): 1 test pattern, 2 binning, 3 full frame
    function automatic int pick_mode(input logic [2:0] r);
        if (r[0]) return 1;
        if (r[2]) return 2;
        if (r[1]) return 3;
        return 0;
    endfunction

    task automatic push_seq(input int m);
        int         n;
        logic [7:0] ab;
        logic [7:0] db;
        case (m)
            1:       begin n = 3; ab = 8'h10; db = 8'hA0; end
            2:       begin n = 4; ab = 8'h20; db = 8'hB0; end
            default: begin n = 2; ab = 8'h30; db = 8'hC0; end
        endcase
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = ab + 8'(i);
            e.d = db + 8'(i);
            e.last = (i == n - 1);
            sb.push_back(e);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wr_req) seen = 1;
        end
        checks++;
        if (seen) begin
            errors++;
            $display("FAIL %s wr_req actual 1 expected 0", tag);
        end
    endtask

    task automatic run_change(input logic [2:0] req, input logic [2:0] later_req,
                              input int delay, input bit drop_ready, input string tag);
        int  guard;
        bit  seen;
        ack_delay = delay;
        push_seq(pick_mode(req));
        @(negedge clk); #1 mode_req = req;
        seen = 0;
        for (int i = 0; i < 50 && !seen; i++) begin
            @(negedge clk);
            if (wr_req) seen = 1;
        end
        checks++;
        if (!seen) begin
            errors++;
            $display("FAIL %s start wr_req actual 0 expected 1", tag);
        end
        #1 mode_req = later_req;
        if (drop_ready) sns_ready = 1'b0;
        guard = 0;
        while (sb.size() > 1 && guard < 200) begin @(negedge clk); guard++; end
        #1 mode_req = 3'b000;
        while (sb.size() > 0 && guard < 400) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL %s pending writes actual %0d expected 0", tag, sb.size());
            sb.delete();
        end
        #1 sns_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (wr_req !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b%0b expected 00", wr_req, done);
        end

        // R2: request while ready low is ignored
        #1 mode_req = 3'b001;
        quiet(20, "R2");
        #1 mode_req = 3'b000;

        // R3: wait in hold, then a late request
        #1 sns_ready = 1'b1;
        quiet(15, "R3");
        run_change(3'b001, 3'b000, 0, 0, "R3 R6");

        // R4: ready falls while waiting
        repeat (3) @(negedge clk);
        #1 sns_ready = 1'b0; mode_req = 3'b100;
        quiet(12, "R4");
        #1 mode_req = 3'b000; sns_ready = 1'b1;
        repeat (3) @(negedge clk);

        // R5 priority and R7 tables
        run_change(3'b111, 3'b000, 1, 0, "R5 all");
        run_change(3'b110, 3'b000, 0, 0, "R5 R7 bin");
        run_change(3'b010, 3'b000, 2, 0, "R7 full");
        run_change(3'b101, 3'b000, 0, 0, "R5 tp");

        // R8: stalled writes
        run_change(3'b100, 3'b000, 3, 0, "R8");

        // R9: request and ready change mid-sequence
        run_change(3'b001, 3'b100, 2, 1, "R9");
        #1 sns_ready = 1'b0;
        quiet(10, "R9");
        #1 sns_ready = 1'b1;

        // R1: reset abandons a sequence
        ack_delay = 5;
        @(negedge clk); #1 mode_req = 3'b100;
        for (int i = 0; i < 50 && !wr_req; i++) @(negedge clk);
        #1 rst = 1'b1; mode_req = 3'b000;
        sb.delete();
        @(negedge clk);
        checks++;
        if (wr_req !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 mid-run reset actual %0b%0b expected 00", wr_req, done);
        end
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        run_change(3'b010, 3'b000, 1, 0, "R1 after reset R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule